// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Qualified Invalidation

This block is a small fully associative translation cache. Each entry maps a 4 KiB virtual page, tagged with a 2-bit address-space number, to a 20-bit physical frame and three permission bits. A requester presents an address-space number and a 32-bit virtual address. One cycle later the block returns hit or miss, the frame number and the permissions. A page walker fills missing translations through a separate fill port. New translations replace entries in round-robin order. A fill for a page that is already cached rewrites that entry in place.

A single 32-bit invalidation command removes entries by scope: every entry, one 4 MiB section, or one 16 KiB group of four pages. Any scope can be narrowed to one address space. The command is accepted in the cycle it is written and applied at the end of the next cycle. During that next cycle, lookups are kept from hitting the entries being removed, and fills are discarded. Two 32-bit counters tally lookup hits and misses while statistics are switched on through a configuration word.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, `res_valid` is 0 and both counters read 0.
- R2: A lookup sampled at a clock edge yields `res_valid` after that edge. `res_hit` is 1 only when a valid entry holds the same address-space number and the same VA[31:12]. On a hit, `res_pfn` gives the entry's frame and `res_perm` gives {readable, writable, nonsecure} in bits 2, 1 and 0. On a miss both are 0.
- R3: An entry for a page under one address-space number never hits a lookup that carries another number.
- R4: A fill whose address-space number and page already sit in a valid entry overwrites that entry and leaves the replacement pointer where it was.
- R5: A fill of a page that is not yet cached is written to the slot under the replacement pointer. The pointer starts at 0 and steps 0, 1, … ENTRIES-1, 0, evicting whatever that slot held.
- R6: Command bits 1:0 = 0 selects every valid entry.
- R7: Command bits 1:0 = 2 selects entries whose VA[31:22] equals command bits 19:10.
- R8: Command bits 1:0 = 3 selects entries whose VA[31:14] equals command bits 19:2.
- R9: When command bit 31 is 1, only entries whose address-space number equals command bits 30:29 are selected. When bit 31 is 0, the address-space number is not compared.
- R10: Command bits 1:0 = 1 selects no entry, and the cache contents are unchanged.
- R11: A command written in cycle t clears its selected entries at the end of cycle t+1. A lookup sampled in cycle t still sees them. A lookup sampled in cycle t+1 does not hit them.
- R12: A fill presented in the cycle after a command write is discarded.
- R13: Bit 31 of the configuration word switches statistics on. While it is set, each lookup adds one to `hit_count` on a hit or to `miss_count` on a miss. While it is clear, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_asid | input | 2 | Address-space number of the lookup |
| lkp_vaddr | input | 32 | Virtual address of the lookup |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup found a translation |
| res_pfn | output | 20 | Physical frame number on a hit |
| res_perm | output | 3 | {readable, writable, nonsecure} on a hit |
| fill_valid | input | 1 | Fill request from the page walker |
| fill_asid | input | 2 | Address-space number of the fill |
| fill_vpn | input | 20 | Virtual page number (VA[31:12]) of the fill |
| fill_pfn | input | 20 | Physical frame number of the fill |
| fill_perm | input | 3 | Permissions of the fill |
| inv_wr | input | 1 | Invalidation command write strobe |
| inv_cmd | input | 32 | Invalidation command word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word; bit 31 enables statistics |
| hit_count | output | 32 | Lookup hit counter |
| miss_count | output | 32 | Lookup miss counter |

## Verification
The bench builds the cache with ENTRIES = 4, so a handful of fills wraps the replacement pointer. This makes eviction order and the in-place rewrite observable through later hits and misses. With the counter width left at 32, the statistics checks compare exact small counts after statistics are switched on and off. Section and group commands are each tried against pages inside and outside the selected range, and under matching and non-matching address-space numbers.

// File: rtl/atlb_pkg.sv
package atlb_pkg;
  localparam int VA_W     = 32;
  localparam int PAGE_SH  = 12;
  localparam int VPN_W    = VA_W - PAGE_SH;
  localparam int PFN_W    = 20;
  localparam int ASID_W   = 2;
  localparam int PERM_W   = 3;

  typedef enum logic [1:0] {
    INV_EVERY   = 2'd0,
    INV_NONE    = 2'd1,
    INV_SECTION = 2'd2,
    INV_GROUP   = 2'd3
  } inv_kind_e;

  typedef struct packed {
    logic              vld;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } tlb_ent_t;
endpackage

// File: rtl/atlb_inv_match.sv
module atlb_inv_match
  import atlb_pkg::*;
(
  input  tlb_ent_t    ent,
  input  logic [31:0] cmd,
  output logic        sel
);
  inv_kind_e kind;
  logic      addr_ok;
  logic      asid_ok;

  always_comb begin
    kind = inv_kind_e'(cmd[1:0]);
    unique case (kind)
      INV_EVERY:   addr_ok = 1'b1;
      INV_SECTION: addr_ok = (ent.vpn[VPN_W-1:10] == cmd[19:10]);
      INV_GROUP:   addr_ok = (ent.vpn[VPN_W-1:2] == cmd[19:2]);
      default:     addr_ok = 1'b0;
    endcase
    asid_ok = !cmd[31] || (ent.asid == cmd[30:29]);
    sel     = ent.vld && addr_ok && asid_ok;
  end
endmodule

// File: rtl/atlb_stat_ctr.sv
module atlb_stat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q)); // R13
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import atlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [ASID_W-1:0] lkp_asid,
  input  logic [VA_W-1:0]   lkp_vaddr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PFN_W-1:0]  res_pfn,
  output logic [PERM_W-1:0] res_perm,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_wr,
  input  logic [31:0]       inv_cmd,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlb_ent_t          ent_q [ENTRIES];
  tlb_ent_t          ent_d [ENTRIES];
  logic [IDX_W-1:0]  rr_q, rr_d;
  logic              fl_pend_q, fl_pend_d;
  logic [31:0]       fl_cmd_q, fl_cmd_d;
  logic              stats_en_q;
  logic              res_valid_q, res_hit_q;
  logic [PFN_W-1:0]  res_pfn_q;
  logic [PERM_W-1:0] res_perm_q;

  logic [ENTRIES-1:0] sel_raw, kill, look_hit, fill_hit;
  logic               look_any, fill_match, fill_take;
  logic [PFN_W-1:0]   look_pfn;
  logic [PERM_W-1:0]  look_perm;
  logic [IDX_W-1:0]   fill_idx;
  logic [VPN_W-1:0]   lkp_vpn;

  assign lkp_vpn = lkp_vaddr[VA_W-1:PAGE_SH];

  // per-entry comparators
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    atlb_inv_match u_inv (
      .ent (ent_q[i]),
      .cmd (fl_cmd_q),
      .sel (sel_raw[i])
    );
    assign kill[i]     = fl_pend_q && sel_raw[i];
    assign look_hit[i] = ent_q[i].vld && !kill[i] &&
                         (ent_q[i].asid == lkp_asid) && (ent_q[i].vpn == lkp_vpn);
    assign fill_hit[i] = ent_q[i].vld &&
                         (ent_q[i].asid == fill_asid) && (ent_q[i].vpn == fill_vpn);

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      kill[i] |=> !ent_q[i].vld); // R11
  end

  // result mux and fill slot choice
  always_comb begin
    look_any   = 1'b0;
    look_pfn   = '0;
    look_perm  = '0;
    fill_match = 1'b0;
    fill_idx   = rr_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_hit[i]) begin
        look_any  = 1'b1;
        look_pfn  = look_pfn | ent_q[i].pfn;
        look_perm = look_perm | ent_q[i].perm;
      end
      if (fill_hit[i]) begin
        fill_match = 1'b1;
        fill_idx   = IDX_W'(i);
      end
    end
  end

  // next state
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      ent_d[i] = ent_q[i];
      if (kill[i]) ent_d[i].vld = 1'b0;
    end
    fill_take = fill_valid && !fl_pend_q;
    if (fill_take) begin
      ent_d[fill_idx] = '{vld: 1'b1, asid: fill_asid, vpn: fill_vpn,
                          pfn: fill_pfn, perm: fill_perm};
    end
    rr_d = rr_q;
    if (fill_take && !fill_match)
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    fl_pend_d = inv_wr;
    fl_cmd_d  = inv_cmd;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
      rr_q       <= '0;
      fl_pend_q  <= 1'b0;
      fl_cmd_q   <= '0;
      stats_en_q <= 1'b0;
      res_valid_q <= 1'b0;
      res_hit_q  <= 1'b0;
      res_pfn_q  <= '0;
      res_perm_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
      rr_q        <= rr_d;
      fl_pend_q   <= fl_pend_d;
      if (inv_wr) fl_cmd_q <= fl_cmd_d;
      if (cfg_wr) stats_en_q <= cfg_wdata[31];
      res_valid_q <= lkp_valid;
      if (lkp_valid) begin
        res_hit_q  <= look_any;
        res_pfn_q  <= look_pfn;
        res_perm_q <= look_perm;
      end
    end
  end

  assign res_valid = res_valid_q;
  assign res_hit   = res_hit_q;
  assign res_pfn   = res_pfn_q;
  assign res_perm  = res_perm_q;

  atlb_stat_ctr #(.W(CNT_W)) u_hit_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (stats_en_q && lkp_valid && look_any),
    .count (hit_count)
  );

  atlb_stat_ctr #(.W(CNT_W)) u_miss_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (stats_en_q && lkp_valid && !look_any),
    .count (miss_count)
  );

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |-> $onehot0(look_hit)); // R4
  AST_FILL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_pend_q && fill_valid) |=> $stable(rr_q)); // R12
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_pfn == '0 && res_perm == '0)); // R2
endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lkp_valid;
  logic [1:0]  lkp_asid;
  logic [31:0] lkp_vaddr;
  logic        res_valid, res_hit;
  logic [19:0] res_pfn;
  logic [2:0]  res_perm;
  logic        fill_valid;
  logic [1:0]  fill_asid;
  logic [19:0] fill_vpn, fill_pfn;
  logic [2:0]  fill_perm;
  logic        inv_wr;
  logic [31:0] inv_cmd;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic [31:0] hit_count, miss_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit        hit;
    bit [19:0] pfn;
    bit [2:0]  perm;
    string     tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  asid_tlb #(.ENTRIES(4)) i_asid_tlb (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_asid(lkp_asid), .lkp_vaddr(lkp_vaddr),
    .res_valid(res_valid), .res_hit(res_hit), .res_pfn(res_pfn), .res_perm(res_perm),
    .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .inv_wr(inv_wr), .inv_cmd(inv_cmd),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  // monitor: compare each result against the oldest expectation
  always @(posedge clk) begin
    #2;
    if (res_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected result hit=%0b pfn=%h", res_hit, res_pfn);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (res_hit !== e.hit || res_pfn !== e.pfn || res_perm !== e.perm) begin
          errors++;
          $display("FAIL %s: got hit=%0b pfn=%h perm=%b, expected hit=%0b pfn=%h perm=%b",
                   e.tag, res_hit, res_pfn, res_perm, e.hit, e.pfn, e.perm);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input bit h, input bit [19:0] p, input bit [2:0] m, input string tag);
    exp_t e;
    e.hit = h; e.pfn = h ? p : 20'h0; e.perm = h ? m : 3'b0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic lookup(input bit [1:0] a, input bit [19:0] vpn, input bit h,
                        input bit [19:0] p, input bit [2:0] m, input string tag);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_asid = a; lkp_vaddr = {vpn, 12'h5A4};
    push(h, p, m, tag);
    @(negedge clk);
    lkp_valid = 1'b0;
  endtask

  task automatic fill(input bit [1:0] a, input bit [19:0] vpn, input bit [19:0] p,
                      input bit [2:0] m);
    @(negedge clk);
    fill_valid = 1'b1; fill_asid = a; fill_vpn = vpn; fill_pfn = p; fill_perm = m;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic inval(input bit [31:0] c);
    @(negedge clk);
    inv_wr = 1'b1; inv_cmd = c;
    @(negedge clk);
    inv_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg(input bit [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    lkp_valid = 0; lkp_asid = 0; lkp_vaddr = 0;
    fill_valid = 0; fill_asid = 0; fill_vpn = 0; fill_pfn = 0; fill_perm = 0;
    inv_wr = 0; inv_cmd = 0; cfg_wr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({31'b0, res_valid}, 32'h0, "R1 res_valid after reset");
    chk(hit_count, 32'h0, "R1 hit_count after reset");
    chk(miss_count, 32'h0, "R1 miss_count after reset");
    lookup(2'd0, 20'h12345, 0, 0, 0, "R1 empty cache misses");

    // R2 basic hit, R3 tag on address space
    fill(2'd0, 20'h12345, 20'hABCDE, 3'b101);
    lookup(2'd0, 20'h12345, 1, 20'hABCDE, 3'b101, "R2 hit after fill");
    lookup(2'd1, 20'h12345, 0, 0, 0, "R3 other address space misses");

    // R4 in-place rewrite, pointer unchanged
    fill(2'd0, 20'h12345, 20'h11111, 3'b110);
    lookup(2'd0, 20'h12345, 1, 20'h11111, 3'b110, "R4 rewritten entry");
    fill(2'd1, 20'h00010, 20'h22222, 3'b111);
    fill(2'd2, 20'h00020, 20'h33333, 3'b001);
    fill(2'd3, 20'h00030, 20'h44444, 3'b010);
    lookup(2'd0, 20'h12345, 1, 20'h11111, 3'b110, "R4 rewrite kept pointer");
    lookup(2'd1, 20'h00010, 1, 20'h22222, 3'b111, "R5 slot1");
    lookup(2'd3, 20'h00030, 1, 20'h44444, 3'b010, "R5 slot3");

    // R5 wrap evicts slot 0
    fill(2'd0, 20'h00040, 20'h55555, 3'b100);
    lookup(2'd0, 20'h12345, 0, 0, 0, "R5 slot0 evicted");
    lookup(2'd0, 20'h00040, 1, 20'h55555, 3'b100, "R5 new page in slot0");
    lookup(2'd1, 20'h00010, 1, 20'h22222, 3'b111, "R5 other slots kept");

    // R11 / R12 timing around a whole-cache command
    @(negedge clk);
    inv_wr = 1'b1; inv_cmd = 32'h0;
    lkp_valid = 1'b1; lkp_asid = 2'd0; lkp_vaddr = {20'h00040, 12'h0};
    push(1, 20'h55555, 3'b100, "R11 lookup in write cycle sees old");
    @(negedge clk);
    inv_wr = 1'b0;
    push(0, 0, 0, "R11 lookup in apply cycle misses");
    fill_valid = 1'b1; fill_asid = 2'd1; fill_vpn = 20'h0ABCD;
    fill_pfn = 20'h66666; fill_perm = 3'b111;
    @(negedge clk);
    lkp_valid = 1'b0; fill_valid = 1'b0;
    lookup(2'd1, 20'h00010, 0, 0, 0, "R6 all entries removed");
    lookup(2'd1, 20'h0ABCD, 0, 0, 0, "R12 fill during apply dropped");

    // R8 / R9 group with address-space qualifier
    fill(2'd1, 20'h40004, 20'h70001, 3'b111);
    fill(2'd2, 20'h40005, 20'h70002, 3'b111);
    fill(2'd1, 20'h40008, 20'h70003, 3'b111);
    inval(32'hA004_0007);
    lookup(2'd1, 20'h40004, 0, 0, 0, "R8 R9 group page removed");
    lookup(2'd2, 20'h40005, 1, 20'h70002, 3'b111, "R9 other space kept");
    lookup(2'd1, 20'h40008, 1, 20'h70003, 3'b111, "R8 other group kept");

    // R7 section, address space ignored
    inval(32'h0);
    fill(2'd0, 20'h00C01, 20'h0C001, 3'b100);
    fill(2'd3, 20'h00DFF, 20'h0C002, 3'b010);
    fill(2'd0, 20'h01001, 20'h0C003, 3'b001);
    inval(32'h0000_0C02);
    lookup(2'd0, 20'h00C01, 0, 0, 0, "R7 section page removed");
    lookup(2'd3, 20'h00DFF, 0, 0, 0, "R7 R9 unqualified ignores space");
    lookup(2'd0, 20'h01001, 1, 20'h0C003, 3'b001, "R7 other section kept");

    // R10 reserved encoding
    inval(32'h0000_1001);
    lookup(2'd0, 20'h01001, 1, 20'h0C003, 3'b001, "R10 encoding 1 removes nothing");

    // R13 statistics
    drain();
    chk(hit_count, 32'h0, "R13 hit_count held while off");
    chk(miss_count, 32'h0, "R13 miss_count held while off");
    inval(32'h0);
    cfg(32'h8000_0000);
    fill(2'd2, 20'h77777, 20'h12321, 3'b011);
    lookup(2'd2, 20'h77777, 1, 20'h12321, 3'b011, "R13 counted hit");
    lookup(2'd2, 20'h77778, 0, 0, 0, "R13 counted miss");
    lookup(2'd1, 20'h77777, 0, 0, 0, "R13 counted miss");
    drain();
    chk(hit_count, 32'd1, "R13 hit_count while on");
    chk(miss_count, 32'd2, "R13 miss_count while on");
    cfg(32'h0);
    lookup(2'd2, 20'h77777, 1, 20'h12321, 3'b011, "R13 uncounted hit");
    drain();
    chk(hit_count, 32'd1, "R13 hit_count after off");
    chk(miss_count, 32'd2, "R13 miss_count after off");
    chk(sb.size(), 32'd0, "R2 every lookup produced a result");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule